// File: doc/BRIEF.md
# Block-Matching SAD Motion Search

This block runs an exhaustive block-matching search for one 4×4 target block. Candidate blocks stream in one pixel pair per accepted beat: each beat carries a candidate pixel, the co-located target pixel, the candidate's index and a marker on the last of the 16 beats. The block adds the absolute pixel differences for the current candidate. When a candidate closes, its total is compared against the lowest total seen so far in the search. The lower of the two is kept, together with the index of the candidate that produced it.

A one-cycle end-of-search pulse asks for the result. On the next cycle the block presents the winning index and its SAD with a one-cycle valid. During that same cycle it holds off the pixel stream and clears its state, so the following search starts fresh. A reported SAD of zero marks an exact match. A search with no candidates reports the all-ones SAD, which stands for "nothing found".

Top module: `sad_motion_search`

## Requirements
- R1: A candidate consists of 16 accepted beats (in_valid and in_ready both high). It closes on the beat whose pix_last is high, and its index is taken from cand_idx on that closing beat.
- R2: Each accepted beat adds |cand_pix − tgt_pix|, with both pixels read as 8-bit unsigned values. The running total restarts at zero for every candidate.
- R3: A search that closes no candidate reports best_idx 0 and best_sad 4095 (all twelve bits set).
- R4: A closed candidate replaces the stored best only when its SAD is strictly lower, so on equal SADs the candidate that closed first is reported.
- R5: search_end sampled high at a clock edge while result_valid is low makes result_valid high for exactly the next cycle, with best_idx and best_sad holding the search's winner.
- R6: A candidate whose pixels all equal the target's pixels is reported with best_sad 0.
- R7: A candidate in which every pixel differs from the target by 255 is reported with best_sad 4080, with no wrap-around.
- R8: At the end of the report cycle, the stored best and the running total are cleared, so the next search is not affected by the previous one.
- R9: in_ready is low exactly in the cycle where result_valid is high. A beat offered in that cycle is not taken and does not reach any later result.
- R10: Cycles with in_valid low between beats leave the running total and the stored best unchanged.
- R11: A candidate closing on the same clock edge that samples search_end takes part in the report it triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel pair offered on this cycle |
| in_ready | output | 1 | Block accepts a pixel pair this cycle |
| cand_pix | input | 8 | Candidate block pixel, unsigned |
| tgt_pix | input | 8 | Target block pixel, unsigned |
| pix_last | input | 1 | Marks the 16th pixel of a candidate |
| cand_idx | input | 8 | Candidate index, sampled on the closing beat |
| search_end | input | 1 | One-cycle request to report and restart |
| result_valid | output | 1 | One-cycle strobe for the report |
| best_idx | output | 8 | Index of the lowest-SAD candidate |
| best_sad | output | 12 | Lowest SAD of the search |

## Verification
A beat updates the running total on the clock edge that accepts it. A closing beat also updates the stored best on that same edge, so no result lags a beat by more than that one edge. A report is the only thing the ports show: result_valid, best_idx and best_sad go valid one edge after search_end is sampled and drop one edge later. The bench therefore checks the report at the falling edge that follows the sampling edge, and checks the cleared state at the falling edge after that. Scenarios that concern stalls, ties, blocked beats and a candidate closing together with search_end are all judged through that one report window, against totals the bench computes from its own pixel arrays.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Implementation choices for the absolute-difference stage
  typedef enum logic {
    ABS_MUX = 1'b0,  // compare, then subtract in the right order
    ABS_NEG = 1'b1   // signed subtract, then conditional negate
  } absdiff_style_e;

  // Width of a sum of n values, each w bits wide
  function automatic int unsigned sum_width(input int unsigned w, input int unsigned n);
    return w + $clog2(n);
  endfunction

endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff
  import sad_pkg::*;
#(
  parameter int unsigned    PIX_W = 8,
  parameter absdiff_style_e STYLE = ABS_MUX
) (
  input  logic [PIX_W-1:0] a_pix,
  input  logic [PIX_W-1:0] b_pix,
  output logic [PIX_W-1:0] diff
);

  generate
    if (STYLE == ABS_MUX) begin : g_mux
      always_comb begin
        if (a_pix >= b_pix) diff = a_pix - b_pix;
        else                diff = b_pix - a_pix;
      end
    end else begin : g_neg
      logic [PIX_W:0] wide;
      logic [PIX_W:0] mag;
      always_comb begin
        wide = {1'b0, a_pix} - {1'b0, b_pix};
        mag  = wide[PIX_W] ? (~wide + 1'b1) : wide;
        diff = mag[PIX_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned BLK_PIX = 16,
  localparam int unsigned SAD_W  = PIX_W + $clog2(BLK_PIX),
  localparam int unsigned CNT_W  = (BLK_PIX > 1) ? $clog2(BLK_PIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             beat,
  input  logic             last,
  input  logic [PIX_W-1:0] diff,
  output logic [SAD_W-1:0] sum_now,
  output logic             done,
  output logic [CNT_W-1:0] beat_cnt
);

  logic [SAD_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  // Total including the beat being accepted right now
  assign sum_now  = acc_q + SAD_W'(diff);
  assign done     = beat & last;
  assign beat_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (beat) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= sum_now;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sad_best.sv
module sad_best #(
  parameter int unsigned SAD_W = 12,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cand_done,
  input  logic [SAD_W-1:0] cand_sum,
  input  logic [IDX_W-1:0] cand_idx,
  output logic [SAD_W-1:0] best_sad_q,
  output logic [SAD_W-1:0] nxt_sad,
  output logic [IDX_W-1:0] nxt_idx
);

  logic [IDX_W-1:0] best_idx_q;
  logic             take;

  // Strict comparison: an equal total never displaces the holder
  assign take    = cand_done && (cand_sum < best_sad_q);
  assign nxt_sad = take ? cand_sum : best_sad_q;
  assign nxt_idx = take ? cand_idx : best_idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      best_sad_q <= '1;
      best_idx_q <= '0;
    end else begin
      best_sad_q <= nxt_sad;
      best_idx_q <= nxt_idx;
    end
  end

endmodule

// File: rtl/sad_motion_search.sv
module sad_motion_search
  import sad_pkg::*;
#(
  parameter int unsigned    PIX_W   = 8,
  parameter int unsigned    IDX_W   = 8,
  parameter int unsigned    BLK_PIX = 16,
  parameter absdiff_style_e ABS_STY = ABS_MUX,
  localparam int unsigned   SAD_W   = PIX_W + $clog2(BLK_PIX),
  localparam int unsigned   CNT_W   = (BLK_PIX > 1) ? $clog2(BLK_PIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] cand_pix,
  input  logic [PIX_W-1:0] tgt_pix,
  input  logic             pix_last,
  input  logic [IDX_W-1:0] cand_idx,
  input  logic             search_end,
  output logic             result_valid,
  output logic [IDX_W-1:0] best_idx,
  output logic [SAD_W-1:0] best_sad
);

  logic             res_valid_q;
  logic [IDX_W-1:0] res_idx_q;
  logic [SAD_W-1:0] res_sad_q;

  logic             beat;
  logic             report_fire;
  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] sum_now;
  logic             cand_done;
  logic [CNT_W-1:0] beat_cnt_w;
  logic [SAD_W-1:0] best_sad_w;
  logic [SAD_W-1:0] nxt_sad;
  logic [IDX_W-1:0] nxt_idx;

  // The stream stalls only while the report is on the outputs
  assign in_ready    = ~res_valid_q;
  assign beat        = in_valid & in_ready;
  assign report_fire = search_end & ~res_valid_q;

  sad_absdiff #(
    .PIX_W (PIX_W),
    .STYLE (ABS_STY)
  ) u_abs (
    .a_pix (cand_pix),
    .b_pix (tgt_pix),
    .diff  (diff)
  );

  sad_accum #(
    .PIX_W   (PIX_W),
    .BLK_PIX (BLK_PIX)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clear    (res_valid_q),
    .beat     (beat),
    .last     (pix_last),
    .diff     (diff),
    .sum_now  (sum_now),
    .done     (cand_done),
    .beat_cnt (beat_cnt_w)
  );

  sad_best #(
    .SAD_W (SAD_W),
    .IDX_W (IDX_W)
  ) u_best (
    .clk        (clk),
    .rst        (rst),
    .clear      (res_valid_q),
    .cand_done  (cand_done),
    .cand_sum   (sum_now),
    .cand_idx   (cand_idx),
    .best_sad_q (best_sad_w),
    .nxt_sad    (nxt_sad),
    .nxt_idx    (nxt_idx)
  );

  // Report register: captures the winner including a same-edge close
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_q <= 1'b0;
      res_idx_q   <= '0;
      res_sad_q   <= '1;
    end else begin
      res_valid_q <= report_fire;
      if (report_fire) begin
        res_idx_q <= nxt_idx;
        res_sad_q <= nxt_sad;
      end
    end
  end

  assign result_valid = res_valid_q;
  assign best_idx     = res_idx_q;
  assign best_sad     = res_sad_q;

endmodule

// File: rtl/sad_motion_search_chk.sv
module sad_motion_search_chk #(
  parameter int unsigned SAD_W   = 12,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned BLK_PIX = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             pix_last,
  input logic             search_end,
  input logic             result_valid,
  input logic [SAD_W-1:0] best_sad_w,
  input logic [CNT_W-1:0] beat_cnt_w
);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R5
  report_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (search_end && !result_valid) |=> result_valid);

  // R9
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready != result_valid);

  // R8
  best_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> (best_sad_w == {SAD_W{1'b1}}));

  // R4
  best_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !result_valid |=> (best_sad_w <= $past(best_sad_w)));

  // R1
  last_on_sixteenth_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && pix_last) |-> (beat_cnt_w == CNT_W'(BLK_PIX - 1)));

endmodule

bind sad_motion_search sad_motion_search_chk #(
  .SAD_W   (SAD_W),
  .CNT_W   (CNT_W),
  .BLK_PIX (BLK_PIX)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .pix_last     (pix_last),
  .search_end   (search_end),
  .result_valid (result_valid),
  .best_sad_w   (best_sad_w),
  .beat_cnt_w   (beat_cnt_w)
);

// File: tb/sim_sad_motion_search.sv
module sim_sad_motion_search;

  localparam int CLK_PERIOD = 10;
  localparam int NPIX       = 16;
  localparam int SADMAX     = 4095;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] cand_pix;
  logic [7:0] tgt_pix;
  logic       pix_last;
  logic [7:0] cand_idx;
  logic       search_end;
  logic       result_valid;
  logic [7:0] best_idx;
  logic [11:0] best_sad;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_sad  = SADMAX;
  int exp_idx  = 0;
  bit finished = 1'b0;

  logic [7:0] cbuf [NPIX];
  logic [7:0] tbuf [NPIX];

  always #(CLK_PERIOD/2) clk = ~clk;

  sad_motion_search u0 (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .cand_pix     (cand_pix),
    .tgt_pix      (tgt_pix),
    .pix_last     (pix_last),
    .cand_idx     (cand_idx),
    .search_end   (search_end),
    .result_valid (result_valid),
    .best_idx     (best_idx),
    .best_sad     (best_sad)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patt(input int seed, input int p);
    return 8'((seed * 37 + p * 53 + 7) & 255);
  endfunction

  task automatic fill(input int cseed, input int tseed);
    for (int p = 0; p < NPIX; p++) begin
      cbuf[p] = patt(cseed, p);
      tbuf[p] = patt(tseed, p);
    end
  endtask

  function automatic int model_sad();
    int s = 0;
    for (int p = 0; p < NPIX; p++) begin
      int d = int'(cbuf[p]) - int'(tbuf[p]);
      s += (d < 0) ? -d : d;
    end
    return s;
  endfunction

  // Streams cbuf/tbuf as one candidate; gap idle cycles after each beat.
  // with_end raises search_end on the closing beat (R11 scenario).
  task automatic send_cand(input int idx, input int gap, input bit with_end);
    int s;
    for (int p = 0; p < NPIX; p++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      cand_pix   = cbuf[p];
      tgt_pix    = tbuf[p];
      pix_last   = (p == NPIX - 1);
      cand_idx   = 8'(idx);
      search_end = with_end && (p == NPIX - 1);
      for (int g = 0; g < gap && p < NPIX - 1; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        cand_pix = 8'hAA;
        pix_last = 1'b1;
      end
    end
    s = model_sad();
    if (s < exp_sad) begin
      exp_sad = s;
      exp_idx = idx;
    end
  endtask

  // Checks the report window; call right after the sampling edge's negedge
  task automatic check_report(input string req);
    check({req, " result_valid"}, int'(result_valid), 1);
    check({req, " in_ready low"}, int'(in_ready), 0);
    check({req, " best_idx"}, int'(best_idx), exp_idx);
    check({req, " best_sad"}, int'(best_sad), exp_sad);
  endtask

  task automatic after_report(input string req);
    @(negedge clk);
    check({req, " result_valid drop"}, int'(result_valid), 0);
    check({req, " in_ready back"}, int'(in_ready), 1);
    exp_sad = SADMAX;
    exp_idx = 0;
  endtask

  task automatic do_report(input string req);
    @(negedge clk);
    in_valid   = 1'b0;
    pix_last   = 1'b0;
    search_end = 1'b1;
    @(negedge clk);
    search_end = 1'b0;
    check_report(req);
    after_report(req);
  endtask

  task automatic t_reset();
    check("R5 reset result_valid", int'(result_valid), 0);
    check("R9 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_empty();
    do_report("R3 empty");
  endtask

  task automatic t_distinct();
    for (int k = 1; k <= 4; k++) begin
      fill(k * 3, 5);
      send_cand(10 + k, 0, 1'b0);
    end
    do_report("R1 R2 R5 distinct");
  endtask

  task automatic t_tie();
    fill(9, 2);
    send_cand(20, 0, 1'b0);
    fill(9, 2);
    send_cand(21, 0, 1'b0);
    check("R4 tie model", exp_idx, 20);
    do_report("R4 tie");
  endtask

  task automatic t_perfect_and_max();
    for (int p = 0; p < NPIX; p++) begin
      cbuf[p] = 8'hFF;
      tbuf[p] = 8'h00;
    end
    send_cand(30, 0, 1'b0);
    check("R7 model", exp_sad, 4080);
    do_report("R7 max diff");
    fill(0, 0);
    fill(4, 6);
    send_cand(31, 0, 1'b0);
    fill(8, 8);
    send_cand(32, 0, 1'b0);
    check("R6 model", exp_sad, 0);
    do_report("R6 perfect");
  endtask

  task automatic t_clear();
    fill(13, 1);
    send_cand(40, 0, 1'b0);
    do_report("R8 first");
    // A worse candidate alone must win the fresh search
    for (int p = 0; p < NPIX; p++) begin
      cbuf[p] = 8'd200;
      tbuf[p] = 8'd0;
    end
    send_cand(41, 0, 1'b0);
    do_report("R8 fresh");
  endtask

  task automatic t_blocked_beat();
    @(negedge clk);
    search_end = 1'b1;
    @(negedge clk);
    search_end = 1'b0;
    check_report("R9 pre");
    // Offer a perfect-match closing beat during the report cycle
    in_valid = 1'b1;
    cand_pix = 8'd0;
    tgt_pix  = 8'd0;
    pix_last = 1'b1;
    cand_idx = 8'd99;
    after_report("R9 pre");
    in_valid = 1'b0;
    pix_last = 1'b0;
    do_report("R9 ignored beat");
  endtask

  task automatic t_stall();
    fill(17, 3);
    send_cand(50, 2, 1'b0);
    fill(18, 3);
    send_cand(51, 3, 1'b0);
    do_report("R10 stall");
  endtask

  task automatic t_same_edge();
    fill(21, 22);
    send_cand(60, 0, 1'b0);
    fill(7, 7);
    send_cand(61, 0, 1'b1);
    @(negedge clk);
    in_valid   = 1'b0;
    pix_last   = 1'b0;
    search_end = 1'b0;
    check("R11 model", exp_idx, 61);
    check_report("R11 same edge");
    after_report("R11 same edge");
  endtask

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    cand_pix = '0;
    tgt_pix = '0;
    pix_last = 1'b0;
    cand_idx = '0;
    search_end = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_empty();
    t_distinct();
    t_tie();
    t_perfect_and_max();
    t_clear();
    t_blocked_beat();
    t_stall();
    t_same_edge();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule